// File: doc/BRIEF.md
# Elastic Clock-Crossing Receive FIFO with Start Threshold

This block moves a continuous stream of 66-bit words (a 64-bit payload and a 2-bit sync header) from a recovered receive clock into a local read clock. The write side stores one word on every write-clock edge. The read side does not drain anything until its synchronised view of the fill level reaches a programmable start level. From that point it hands out one word on every read-clock edge. A lower start level gives less latency but less room for wander between the two clocks.

Both pointers cross between the domains as gray code through multi-stage synchronisers. If the write side finds the store full, or the read side finds it empty while streaming, the block raises a one-cycle error pulse. It then forces itself through a reset of at least four read cycles, clears both pointers and refills toward the start level with no outside help. The block also holds the FIFO in reset while its reset input is high or the clocks are not reported stable. When reading begins, the block captures the occupancy it saw at that moment as the latency through the FIFO, in read-clock cycles. Each cycle is worth 66 UI.

Top module: `elastic_cdc_fifo`

## Requirements
- R1: While `rd_rst_in` is high, or after `clocks_stable` has been low for three read cycles, `rd_valid`, `latency_valid` and `fifo_err` stay low.
- R2: Words come out in the order they were written, each header with its own payload, with no word lost or repeated within a run.
- R3: Reading is enabled only once the synchronised occupancy is at least the effective start level, which is `start_level`, or 1 when `start_level` is 0. `latency_valid` rises at that moment, and `rd_valid` is never high while `latency_valid` is low.
- R4: `latency` is the synchronised occupancy seen when reading was enabled, so it is never below the effective start level. It stays constant while `latency_valid` is high.
- R5: A write arriving while the store holds 2^ADDR_W words is dropped and leads to a `fifo_err` pulse on the read side.
- R6: Finding the store empty while streaming leads to a `fifo_err` pulse.
- R7: `rd_valid` and `latency_valid` are low in the cycle in which `fifo_err` is high and stay low for at least four more read cycles. The FIFO then refills and restarts by itself.
- R8: `fifo_err` is high for exactly one read cycle per error.
- R9: Once streaming, `rd_valid` is high on every read cycle until an error or a reset ends the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_data | input | 64 | Payload written each write cycle |
| wr_hdr | input | 2 | Sync header paired with the payload |
| rd_clk | input | 1 | Local read clock |
| rd_rst_in | input | 1 | Active-high reset, read domain |
| clocks_stable | input | 1 | High when both clocks are stable; asynchronous |
| start_level | input | 9 | Fill level at which reading starts (0 acts as 1) |
| rd_data | output | 64 | Payload read out |
| rd_hdr | output | 2 | Header read out |
| rd_valid | output | 1 | Read word valid |
| fifo_err | output | 1 | One-cycle pulse on overflow or underflow |
| latency | output | 16 | Captured occupancy in read cycles |
| latency_valid | output | 1 | `latency` valid and reading enabled |

## Verification
The bench goes after three kinds of fault.

- **Start gating.** It uses a start level of 0, a very low level and the usual 64. A design that compared against the raw 0 would start on an empty store and spin in error. A design with an off-by-one in the gate would report a latency outside [level, level+1].
- **Rate mismatch.** It runs the write clock faster, then slower, than the read clock. This forces overflow and underflow. A design that did not recover would stay silent after the first error, and one that did not pulse would hold `fifo_err` high.
- **Stream integrity.** Payloads are sequence numbers with headers derived from them. Any pointer-crossing fault shows up as a skipped or repeated word, and a short reset hold shows up as `rd_valid` returning within four cycles of the error.

// File: rtl/efifo_pkg.sv
package efifo_pkg;
   typedef enum logic [1:0] {
      ST_HOLD = 2'd0,
      ST_FILL = 2'd1,
      ST_RUN  = 2'd2
   } rd_state_t;
endpackage

// File: rtl/ptr_sync.sv
module ptr_sync #(
   parameter int W      = 10,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         srst,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] bin_out
);
   logic [W-1:0] q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("ptr_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (srst) q[0] <= '0;
               else      q[0] <= gray_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (srst) q[s] <= '0;
               else      q[s] <= q[s-1];
            end
         end
      end
   endgenerate

   always_comb begin
      bin_out[W-1] = q[STAGES-1][W-1];
      for (int i = W - 2; i >= 0; i--) begin
         bin_out[i] = bin_out[i+1] ^ q[STAGES-1][i];
      end
   end
endmodule

// File: rtl/efifo_wr_port.sv
module efifo_wr_port #(
   parameter int ADDR_W = 9,
   parameter int STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              fifo_rst,
   input  logic [ADDR_W:0]   rptr_gray,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic [ADDR_W:0]   wptr_gray,
   output logic              ovf
);
   localparam int PW = ADDR_W + 1;
   localparam logic [PW-1:0] FULL_CNT = PW'(1) << ADDR_W;

   logic [STAGES-1:0] rst_sh;
   logic              wrst;
   logic [PW-1:0]     wptr, rbin_s, wptr_nxt;
   logic              full;

   always_ff @(posedge wr_clk or posedge fifo_rst) begin
      if (fifo_rst) rst_sh <= '1;
      else          rst_sh <= {rst_sh[STAGES-2:0], 1'b0};
   end
   assign wrst = rst_sh[STAGES-1];

   ptr_sync #(.W(PW), .STAGES(STAGES)) rsync_i (
      .clk(wr_clk), .srst(wrst), .gray_in(rptr_gray), .bin_out(rbin_s)
   );

   assign full     = (wptr - rbin_s) == FULL_CNT;
   assign we       = !wrst && !full;
   assign waddr    = wptr[ADDR_W-1:0];
   assign wptr_nxt = wptr + PW'(1);

   always_ff @(posedge wr_clk) begin
      if (wrst) begin
         wptr      <= '0;
         wptr_gray <= '0;
         ovf       <= 1'b0;
      end else if (full) begin
         ovf <= 1'b1;
      end else begin
         wptr      <= wptr_nxt;
         wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
      end
   end
endmodule

// File: rtl/efifo_rd_ctrl.sv
module efifo_rd_ctrl
   import efifo_pkg::*;
#(
   parameter int ADDR_W   = 9,
   parameter int STAGES   = 2,
   parameter int LAT_W    = 16,
   parameter int RST_HOLD = 4
) (
   input  logic              rd_clk,
   input  logic              rd_rst_in,
   input  logic              clocks_stable,
   input  logic [ADDR_W-1:0] start_level,
   input  logic [ADDR_W:0]   wptr_gray,
   input  logic              ovf_async,
   output logic              fifo_rst,
   output logic              rd_en,
   output logic [ADDR_W-1:0] raddr,
   output logic [ADDR_W:0]   rptr_gray,
   output logic              rd_valid,
   output logic              fifo_err,
   output logic [LAT_W-1:0]  latency,
   output logic              latency_valid
);
   localparam int PW    = ADDR_W + 1;
   localparam int CNT_W = $clog2(RST_HOLD + 1);

   rd_state_t      state;
   logic [CNT_W-1:0] hold_cnt;
   logic [PW-1:0]  rptr, rptr_nxt, wbin_s, occ, thr_eff;
   logic           stable_s, ovf_s, rst_req, quit_err;

   ptr_sync #(.W(1), .STAGES(STAGES)) stab_i (
      .clk(rd_clk), .srst(rd_rst_in), .gray_in(clocks_stable), .bin_out(stable_s)
   );
   ptr_sync #(.W(1), .STAGES(STAGES)) ovf_i (
      .clk(rd_clk), .srst(fifo_rst), .gray_in(ovf_async), .bin_out(ovf_s)
   );
   ptr_sync #(.W(PW), .STAGES(STAGES)) wsync_i (
      .clk(rd_clk), .srst(fifo_rst), .gray_in(wptr_gray), .bin_out(wbin_s)
   );

   assign rst_req  = !stable_s;
   assign fifo_rst = (state == ST_HOLD);
   assign occ      = wbin_s - rptr;
   assign thr_eff  = (start_level == '0) ? PW'(1) : {1'b0, start_level};
   assign quit_err = ovf_s || (occ == '0);
   assign rd_en    = (state == ST_RUN) && !rst_req && !quit_err;
   assign raddr    = rptr[ADDR_W-1:0];

   always_comb begin
      if (state == ST_HOLD) rptr_nxt = '0;
      else if (rd_en)       rptr_nxt = rptr + PW'(1);
      else                  rptr_nxt = rptr;
   end

   always_ff @(posedge rd_clk or posedge rd_rst_in) begin
      if (rd_rst_in) begin
         state         <= ST_HOLD;
         hold_cnt      <= '0;
         rptr          <= '0;
         rptr_gray     <= '0;
         latency       <= '0;
         latency_valid <= 1'b0;
         rd_valid      <= 1'b0;
         fifo_err      <= 1'b0;
      end else begin
         rptr      <= rptr_nxt;
         rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
         rd_valid  <= rd_en;
         fifo_err  <= 1'b0;
         case (state)
            ST_HOLD: begin
               latency_valid <= 1'b0;
               if (rst_req)                             hold_cnt <= '0;
               else if (hold_cnt == CNT_W'(RST_HOLD-1)) state    <= ST_FILL;
               else                                     hold_cnt <= hold_cnt + CNT_W'(1);
            end
            ST_FILL: begin
               if (rst_req || ovf_s) begin
                  state    <= ST_HOLD;
                  hold_cnt <= '0;
                  fifo_err <= !rst_req;
               end else if (occ >= thr_eff) begin
                  state         <= ST_RUN;
                  latency       <= LAT_W'(occ);
                  latency_valid <= 1'b1;
               end
            end
            default: begin
               if (rst_req || quit_err) begin
                  state         <= ST_HOLD;
                  hold_cnt      <= '0;
                  latency_valid <= 1'b0;
                  fifo_err      <= !rst_req;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/elastic_cdc_fifo.sv
module elastic_cdc_fifo #(
   parameter int DATA_W   = 64,
   parameter int HDR_W    = 2,
   parameter int ADDR_W   = 9,
   parameter int LAT_W    = 16,
   parameter int STAGES   = 2,
   parameter int RST_HOLD = 4
) (
   input  logic              wr_clk,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [HDR_W-1:0]  wr_hdr,
   input  logic              rd_clk,
   input  logic              rd_rst_in,
   input  logic              clocks_stable,
   input  logic [ADDR_W-1:0] start_level,
   output logic [DATA_W-1:0] rd_data,
   output logic [HDR_W-1:0]  rd_hdr,
   output logic              rd_valid,
   output logic              fifo_err,
   output logic [LAT_W-1:0]  latency,
   output logic              latency_valid
);
   localparam int WORD_W = DATA_W + HDR_W;
   localparam int DEPTH  = 1 << ADDR_W;

   generate
      if (LAT_W < ADDR_W + 1) begin : g_bad_lat
         $error("LAT_W must hold a full occupancy count");
      end
      if (RST_HOLD < STAGES + 2) begin : g_bad_hold
         $error("RST_HOLD too short for the reset to reach the write side");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] mem [DEPTH];
   logic [WORD_W-1:0] rd_word;
   logic              we, rd_en, fifo_rst, ovf;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [ADDR_W:0]   wptr_gray, rptr_gray;

   efifo_wr_port #(.ADDR_W(ADDR_W), .STAGES(STAGES)) wr_i (
      .wr_clk(wr_clk), .fifo_rst(fifo_rst), .rptr_gray(rptr_gray),
      .we(we), .waddr(waddr), .wptr_gray(wptr_gray), .ovf(ovf)
   );

   efifo_rd_ctrl #(.ADDR_W(ADDR_W), .STAGES(STAGES), .LAT_W(LAT_W),
                   .RST_HOLD(RST_HOLD)) rd_i (
      .rd_clk(rd_clk), .rd_rst_in(rd_rst_in), .clocks_stable(clocks_stable),
      .start_level(start_level), .wptr_gray(wptr_gray), .ovf_async(ovf),
      .fifo_rst(fifo_rst), .rd_en(rd_en), .raddr(raddr), .rptr_gray(rptr_gray),
      .rd_valid(rd_valid), .fifo_err(fifo_err), .latency(latency),
      .latency_valid(latency_valid)
   );

   always_ff @(posedge wr_clk) begin
      if (we) mem[waddr] <= {wr_hdr, wr_data};
   end

   always_ff @(posedge rd_clk) begin
      if (rd_en) rd_word <= mem[raddr];
   end

   assign {rd_hdr, rd_data} = rd_word;
endmodule

// File: rtl/efifo_chk.sv
module efifo_chk #(
   parameter int ADDR_W = 9,
   parameter int LAT_W  = 16
) (
   input logic              rd_clk,
   input logic              rd_rst_in,
   input logic [ADDR_W-1:0] start_level,
   input logic              rd_valid,
   input logic              fifo_err,
   input logic [LAT_W-1:0]  latency,
   input logic              latency_valid
);
   logic [LAT_W-1:0] thr_eff;
   assign thr_eff = (start_level == '0) ? LAT_W'(1) : LAT_W'(start_level);

   // R3
   read_gated_chk: assert property (@(posedge rd_clk) disable iff (rd_rst_in)
      rd_valid |-> latency_valid);

   // R3
   rise_after_enable_chk: assert property (@(posedge rd_clk) disable iff (rd_rst_in)
      $rose(rd_valid) |-> $past(latency_valid));

   // R4
   latency_floor_chk: assert property (@(posedge rd_clk) disable iff (rd_rst_in)
      $rose(latency_valid) |-> latency >= thr_eff);

   // R4
   latency_hold_chk: assert property (@(posedge rd_clk) disable iff (rd_rst_in)
      (latency_valid && $past(latency_valid)) |-> $stable(latency));

   // R7
   err_stops_chk: assert property (@(posedge rd_clk) disable iff (rd_rst_in)
      fifo_err |-> (!rd_valid && !latency_valid));

   // R7
   err_hold_chk: assert property (@(posedge rd_clk) disable iff (rd_rst_in)
      fifo_err |=> (!rd_valid && !latency_valid));

   // R8
   err_pulse_chk: assert property (@(posedge rd_clk) disable iff (rd_rst_in)
      fifo_err |=> !fifo_err);
endmodule

bind elastic_cdc_fifo efifo_chk #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) chk_i (
   .rd_clk(rd_clk), .rd_rst_in(rd_rst_in), .start_level(start_level),
   .rd_valid(rd_valid), .fifo_err(fifo_err), .latency(latency),
   .latency_valid(latency_valid)
);

// File: tb/elastic_cdc_fifo_tb.sv
`timescale 1ns/1ps
module elastic_cdc_fifo_tb_top;
   logic        wr_clk = 1'b0, rd_clk = 1'b0;
   logic [63:0] wr_data;
   logic [1:0]  wr_hdr;
   logic        rd_rst_in = 1'b1, clocks_stable = 1'b0;
   logic [8:0]  start_level = 9'd64;
   logic [63:0] rd_data;
   logic [1:0]  rd_hdr;
   logic        rd_valid, fifo_err, latency_valid;
   logic [15:0] latency;

   real         whalf = 10.0;
   longint unsigned wseq = 0;
   int          checks = 0, failures = 0;
   bit          rst_window = 1'b1, done = 1'b0;

   // model state
   bit          p_valid = 0, p_err = 0, p_lv = 0;
   logic [63:0] p_data = '0;
   logic [15:0] p_lat = '0;
   int          since_err = 100;
   int          err_seen = 0;

   elastic_cdc_fifo dut_i (
      .wr_clk(wr_clk), .wr_data(wr_data), .wr_hdr(wr_hdr),
      .rd_clk(rd_clk), .rd_rst_in(rd_rst_in), .clocks_stable(clocks_stable),
      .start_level(start_level), .rd_data(rd_data), .rd_hdr(rd_hdr),
      .rd_valid(rd_valid), .fifo_err(fifo_err), .latency(latency),
      .latency_valid(latency_valid)
   );

   always #10 rd_clk = ~rd_clk;
   initial begin
      #7;
      forever #(whalf) wr_clk = ~wr_clk;
   end

   assign wr_data = wseq;
   assign wr_hdr  = wseq[1:0] ^ 2'b10;
   always @(negedge wr_clk) wseq <= wseq + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // cycle-by-cycle reference comparison
   always @(negedge rd_clk) begin
      if (!done && !rd_rst_in) begin
         if (fifo_err) begin
            err_seen++;
            chk(!p_err, "R8", "fifo_err width", 2, 1);
            since_err = 0;
         end else if (since_err < 100) begin
            since_err++;
         end
         if (since_err >= 1 && since_err <= 4)
            chk(!rd_valid && !latency_valid, "R7", "valid during hold", rd_valid, 0);
         if (rd_valid) begin
            chk(latency_valid, "R3", "rd_valid without latency_valid", latency_valid, 1);
            chk(rd_hdr == (rd_data[1:0] ^ 2'b10), "R2", "header pairing",
                rd_hdr, rd_data[1:0] ^ 2'b10);
            if (p_valid)
               chk(rd_data == p_data + 1, "R2", "sequence", rd_data, p_data + 1);
         end
         if (latency_valid && p_lv)
            chk(latency == p_lat, "R4", "latency changed", latency, p_lat);
         if (p_valid && !rd_valid && !fifo_err && !rst_window)
            chk(1'b0, "R9", "stream gap", 0, 1);
      end
      p_valid = rd_valid && !rd_rst_in;
      p_err   = fifo_err && !rd_rst_in;
      p_lv    = latency_valid && !rd_rst_in;
      p_data  = rd_data;
      p_lat   = latency;
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge rd_clk);
   endtask

   task automatic restart(input logic [8:0] lvl);
      rst_window = 1'b1;
      @(negedge rd_clk);
      rd_rst_in = 1'b1;
      cyc(8);
      start_level = lvl;
      rd_rst_in = 1'b0;
   endtask

   task automatic wait_start(input logic [8:0] lvl, input string req);
      int n;
      int eff;
      n = 0;
      eff = (lvl == 0) ? 1 : int'(lvl);
      while (!latency_valid && n < 3000) begin
         @(negedge rd_clk);
         n++;
      end
      chk(latency_valid, req, "reading enabled", latency_valid, 1);
      chk(int'(latency) >= eff && int'(latency) <= eff + 1, "R4",
          "latency at start", latency, eff);
      rst_window = 1'b0;
   endtask

   task automatic wait_err(input string req);
      int n;
      int base;
      n = 0;
      base = err_seen;
      while (err_seen == base && n < 6000) begin
         @(negedge rd_clk);
         n++;
      end
      chk(err_seen > base, req, "error pulse seen", err_seen - base, 1);
   endtask

   initial begin
      cyc(10);
      // R1: reset holds everything low
      chk(!rd_valid && !latency_valid && !fifo_err, "R1", "outputs in reset",
          {rd_valid, latency_valid, fifo_err}, 0);
      rd_rst_in = 1'b0;
      cyc(100);
      chk(!rd_valid && !latency_valid && !fifo_err, "R1", "clocks not stable",
          {rd_valid, latency_valid, fifo_err}, 0);
      clocks_stable = 1'b1;
      wait_start(9'd64, "R3");
      cyc(500);
      chk(rd_valid && err_seen == 0, "R9", "balanced rates streaming", rd_valid, 1);

      // R1: clocks reported unstable mid-stream
      rst_window = 1'b1;
      clocks_stable = 1'b0;
      cyc(4);
      for (int i = 0; i < 50; i++) begin
         chk(!rd_valid && !latency_valid && !fifo_err, "R1", "unstable hold",
             {rd_valid, latency_valid, fifo_err}, 0);
         @(negedge rd_clk);
      end
      clocks_stable = 1'b1;
      wait_start(9'd64, "R1");

      // R3: low and zero start levels
      restart(9'd4);
      wait_start(9'd4, "R3");
      cyc(200);
      restart(9'd0);
      wait_start(9'd0, "R3");
      cyc(200);

      // R5, R7: overflow with a fast write clock
      restart(9'd64);
      whalf = 7.5;
      wait_start(9'd64, "R5");
      wait_err("R5");
      wait_start(9'd64, "R7");

      // R6, R7: underflow with a slow write clock
      restart(9'd32);
      whalf = 12.5;
      wait_start(9'd32, "R6");
      wait_err("R6");
      wait_start(9'd32, "R7");
      cyc(20);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #4000000;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule